// File: doc/BRIEF.md
# Threshold-Started Transmit FIFO Controller

This block holds outgoing Ethernet frame words between a DMA-style producer and the MAC transmit engine. It decides when the engine may begin sending a frame. The start request is raised when enough entries are buffered to meet a programmable threshold. It is also raised as soon as a whole frame, up to and including its end word, is held, whatever the threshold. A service request asks the producer for more data whenever the occupied count is below a low watermark.

The usable FIFO depth is picked by a size selector from four powers of two. A configuration check raises an error flag when the watermark and the threshold leave less than four entries of slack in the selected depth. The threshold register only takes writes while the transmitter reports idle.

In half-duplex operation, words already handed to the engine keep their space until the collision window closes or the frame ends. A collision inside that window therefore rewinds the read side to the first word of the frame, and the frame is sent again without asking the producer for it. In full-duplex operation, space is freed as each word is read. When the engine pulls from an empty FIFO in the middle of a frame, an underrun status pulse is reported.

Top module: `txStartFifo`

## Requirements
- R1: `txStart` is 1 when no frame is being read and the readable word count is at least `thrCur` (and nonzero).
- R2: `txStart` is 1 below the threshold when a word flagged with `pushLast` = 1 is buffered and not yet read.
- R3: A write on `thrWrEn` updates `thrCur` only when `txIdle` is 1. At any other time the write is ignored.
- R4: `cfgErr` is 1 exactly when `lowMark` + `thrCur` + 4 exceeds the selected depth. The depth is 8 << `sizeSel` with the default parameters: 0→8, 1→16, 2→32, 3→64.
- R5: With `halfDuplex` = 1, read words of the current frame stay counted as occupied, and keep `pushReady` low when the FIFO is full. They are freed together when `colWindowDone` is pulsed.
- R6: `underrun` pulses for one cycle, one clock after `popReq` finds no readable word while a frame is partly read. It stays 0 when the FIFO is empty between frames.
- R7: With `halfDuplex` = 1, a `collision` while the window is open rewinds reading to the frame's first word. The rewind takes precedence over a pop in the same cycle, and `txStart` is raised again.
- R8: `svcReq` is 1 after a clock edge that leaves the occupied count below `lowMark`, and 0 otherwise.
- R9: With `halfDuplex` = 0, each read word frees its entry at once.
- R10: A push is refused (`pushReady` = 0) when the occupied count equals the depth. A pop is refused (`popValid` = 0) when no word is readable.
- R11: During and right after reset, `txStart`, `svcReq`, `underrun` and `popValid` are 0, and `pushReady` is 1.
- R12: Words leave in the order they were accepted, each with its `pushLast` flag.
- R13: With `halfDuplex` = 1, reading the end word of a frame frees all of that frame's held entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sizeSel | input | 2 | Depth selector, depth = (2**AW/8) << sizeSel |
| lowMark | input | 5 | Low watermark for the service request |
| halfDuplex | input | 1 | 1 keeps sent words for retransmission |
| txIdle | input | 1 | Transmitter idle; gates threshold writes |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | AW+1 | New threshold value |
| pushValid | input | 1 | Producer offers a word |
| pushData | input | DW | Word data |
| pushLast | input | 1 | Word ends a frame |
| pushReady | output | 1 | Space is available; a push is accepted |
| popReq | input | 1 | Engine takes the head word this cycle |
| popValid | output | 1 | A readable word is present |
| popData | output | DW | Head word data |
| popLast | output | 1 | Head word ends a frame |
| collision | input | 1 | Collision seen by the engine |
| colWindowDone | input | 1 | Collision window of the current frame elapsed |
| txStart | output | 1 | Transmit start request to the engine |
| svcReq | output | 1 | Service request to the producer |
| underrun | output | 1 | Mid-frame empty pulse |
| cfgErr | output | 1 | Watermark plus threshold too large for depth |
| thrCur | output | AW+1 | Current threshold value |

## Verification
The collision rewind and a pop can fall in the same cycle. The rewind must win, so the word offered that cycle is not consumed and the read side returns to the frame start. The bench raises `collision` while `popReq` is still held in half-duplex mode, three words into a frame. It then puts the already-sent words back at the head of its expected queue. The scoreboard checks that the resent stream repeats those words in order with nothing skipped, and that `txStart` is raised again. A second overlap comes from pushes and pops in the same cycle near the full boundary. There, `pushReady` must follow the occupied count, which in half-duplex mode still includes the held words.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Strobes the control issues to the datapath each cycle
  typedef struct packed {
    logic push;    // store the offered word
    logic pop;     // advance the read pointer
    logic rewind;  // return read pointer to the held frame start
    logic freeUp;  // move the release pointer up to the read pointer
  } txfStrobe_t;

endpackage

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW:0]   depth,
  input  txfStrobe_t    strobe,
  input  logic [DW-1:0] pushData,
  input  logic          pushLast,
  output logic [DW-1:0] popData,
  output logic          popLastBit,
  output logic [AW:0]   used,
  output logic [AW:0]   usedNext,
  output logic [AW:0]   avail
);

  localparam int MAXD = 1 << AW;
  localparam int CW   = AW + 1;

  logic [DW:0]   mem [MAXD];
  logic [AW-1:0] wrPtr, rdPtr, relPtr, rdPtrNext;
  logic [CW-1:0] availNext;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [AW:0] d);
    return ({1'b0, p} == d - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {pushLast, pushData};
  end

  assign {popLastBit, popData} = mem[rdPtr];

  always_comb begin
    if (strobe.rewind)   rdPtrNext = relPtr;
    else if (strobe.pop) rdPtrNext = bump(rdPtr, depth);
    else                 rdPtrNext = rdPtr;

    if (strobe.rewind) availNext = used + CW'(strobe.push);
    else               availNext = avail + CW'(strobe.push) - CW'(strobe.pop);

    usedNext = strobe.freeUp ? availNext : used + CW'(strobe.push);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      relPtr <= '0;
      used   <= '0;
      avail  <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr, depth);
      rdPtr <= rdPtrNext;
      if (strobe.freeUp) relPtr <= rdPtrNext;
      used  <= usedNext;
      avail <= availNext;
    end
  end

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int AW       = 6,
  parameter int THR_INIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  sizeSel,
  input  logic [4:0]  lowMark,
  input  logic        halfDuplex,
  input  logic        txIdle,
  input  logic        thrWrEn,
  input  logic [AW:0] thrWrData,
  input  logic        pushValid,
  input  logic        pushLast,
  input  logic        popReq,
  input  logic        collision,
  input  logic        colWindowDone,
  input  logic [AW:0] used,
  input  logic [AW:0] usedNext,
  input  logic [AW:0] avail,
  input  logic        popLastBit,
  output txfStrobe_t  strobe,
  output logic [AW:0] depth,
  output logic        pushReady,
  output logic        popValid,
  output logic        txStart,
  output logic        svcReq,
  output logic        underrun,
  output logic        cfgErr,
  output logic [AW:0] thrCur
);

  localparam int CW        = AW + 1;
  localparam int SW        = CW + 2;
  localparam int BASE_DEPTH = (1 << AW) >> 3;

  logic [CW-1:0] thr, frmCnt;
  logic          midFrame, winOpen, winOpenNext;
  logic          pushFire, popFire, lastFire, rewindNow;

  assign depth     = CW'(BASE_DEPTH) << sizeSel;
  assign pushReady = used < depth;
  assign popValid  = avail != '0;
  assign rewindNow = halfDuplex && collision && winOpen;
  assign pushFire  = pushValid && pushReady;
  assign popFire   = popReq && popValid && !rewindNow;
  assign lastFire  = popFire && popLastBit;

  always_comb begin
    if (rewindNow || lastFire || colWindowDone) winOpenNext = 1'b0;
    else if (popFire && !midFrame && halfDuplex) winOpenNext = 1'b1;
    else winOpenNext = winOpen;
  end

  always_comb begin
    strobe.push   = pushFire;
    strobe.pop    = popFire;
    strobe.rewind = rewindNow;
    strobe.freeUp = !halfDuplex || !winOpenNext;
  end

  assign txStart = !midFrame && popValid && ((avail >= thr) || (frmCnt != '0));
  assign cfgErr  = (SW'(lowMark) + SW'(thr) + SW'(4)) > SW'(depth);
  assign thrCur  = thr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thr      <= CW'(THR_INIT);
      frmCnt   <= '0;
      midFrame <= 1'b0;
      winOpen  <= 1'b0;
      svcReq   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (thrWrEn && txIdle) thr <= thrWrData;
      frmCnt <= frmCnt + CW'(pushFire && pushLast) - CW'(lastFire);
      if (rewindNow || lastFire) midFrame <= 1'b0;
      else if (popFire)          midFrame <= 1'b1;
      winOpen  <= winOpenNext;
      svcReq   <= SW'(usedNext) < SW'(lowMark);
      underrun <= popReq && midFrame && !popValid && !rewindNow;
    end
  end

endmodule

// File: rtl/txStartFifo.sv
module txStartFifo
  import txf_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 6,
  parameter int THR_INIT = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    sizeSel,
  input  logic [4:0]    lowMark,
  input  logic          halfDuplex,
  input  logic          txIdle,
  input  logic          thrWrEn,
  input  logic [AW:0]   thrWrData,
  input  logic          pushValid,
  input  logic [DW-1:0] pushData,
  input  logic          pushLast,
  output logic          pushReady,
  input  logic          popReq,
  output logic          popValid,
  output logic [DW-1:0] popData,
  output logic          popLast,
  input  logic          collision,
  input  logic          colWindowDone,
  output logic          txStart,
  output logic          svcReq,
  output logic          underrun,
  output logic          cfgErr,
  output logic [AW:0]   thrCur
);

  txfStrobe_t  strobe;
  logic [AW:0] depth, used, usedNext, avail;
  logic        popLastBit;

  txf_ctrl #(.AW(AW), .THR_INIT(THR_INIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .lowMark(lowMark),
    .halfDuplex(halfDuplex), .txIdle(txIdle), .thrWrEn(thrWrEn),
    .thrWrData(thrWrData), .pushValid(pushValid), .pushLast(pushLast),
    .popReq(popReq), .collision(collision), .colWindowDone(colWindowDone),
    .used(used), .usedNext(usedNext), .avail(avail), .popLastBit(popLastBit),
    .strobe(strobe), .depth(depth), .pushReady(pushReady), .popValid(popValid),
    .txStart(txStart), .svcReq(svcReq), .underrun(underrun), .cfgErr(cfgErr),
    .thrCur(thrCur)
  );

  txf_datapath #(.DW(DW), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .depth(depth), .strobe(strobe),
    .pushData(pushData), .pushLast(pushLast), .popData(popData),
    .popLastBit(popLastBit), .used(used), .usedNext(usedNext), .avail(avail)
  );

  assign popLast = popLastBit;

endmodule

// File: rtl/txStartFifo_chk.sv
module txStartFifo_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  sizeSel,
  input logic        txIdle,
  input logic [AW:0] thrCur,
  input logic        pushValid,
  input logic        pushReady,
  input logic        popReq,
  input logic        popValid,
  input logic        colWindowDone,
  input logic        collision,
  input logic        txStart,
  input logic        underrun
);

  AST_THR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !txIdle |=> $stable(thrCur)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!pushReady && !popReq && !colWindowDone && $stable(sizeSel)) |=> (!pushReady || !$stable(sizeSel))); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!popValid && !pushValid && !collision) |=> !popValid); // R10

  AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> popValid); // R1

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(popReq && !popValid)); // R6

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun || $past(popReq)); // R6

endmodule

bind txStartFifo txStartFifo_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .txIdle(txIdle), .thrCur(thrCur),
  .pushValid(pushValid), .pushReady(pushReady), .popReq(popReq),
  .popValid(popValid), .colWindowDone(colWindowDone), .collision(collision),
  .txStart(txStart), .underrun(underrun)
);

// File: tb/txStartFifo_tb_top.sv
module txStartFifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    sizeSel = 2'd0;
  logic [4:0]    lowMark = 5'd2;
  logic          halfDuplex = 1'b0;
  logic          txIdle = 1'b0;
  logic          thrWrEn = 1'b0;
  logic [AW:0]   thrWrData = '0;
  logic          pushValid = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic          pushLast = 1'b0;
  logic          pushReady;
  logic          popReq = 1'b0;
  logic          popValid;
  logic [DW-1:0] popData;
  logic          popLast;
  logic          collision = 1'b0;
  logic          colWindowDone = 1'b0;
  logic          txStart, svcReq, underrun, cfgErr;
  logic [AW:0]   thrCur;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DW:0] expQ[$];
  logic [DW:0] curFrame[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txStartFifo #(.DW(DW), .AW(AW), .THR_INIT(2)) dut_i (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .lowMark(lowMark),
    .halfDuplex(halfDuplex), .txIdle(txIdle), .thrWrEn(thrWrEn),
    .thrWrData(thrWrData), .pushValid(pushValid), .pushData(pushData),
    .pushLast(pushLast), .pushReady(pushReady), .popReq(popReq),
    .popValid(popValid), .popData(popData), .popLast(popLast),
    .collision(collision), .colWindowDone(colWindowDone), .txStart(txStart),
    .svcReq(svcReq), .underrun(underrun), .cfgErr(cfgErr), .thrCur(thrCur)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Driver: offer one word, queue it as expected only if it is accepted
  task automatic pushWord(input logic [DW-1:0] d, input logic last);
    pushValid = 1'b1;
    pushData  = d;
    pushLast  = last;
    if (pushReady) expQ.push_back({last, d});
    tick();
    pushValid = 1'b0;
    pushLast  = 1'b0;
  endtask

  task automatic popWords(input int n);
    popReq = 1'b1;
    for (int i = 0; i < n; i++) tick();
    popReq = 1'b0;
  endtask

  // Monitor: each accepted pop is compared against the queue head (R12)
  always @(negedge clk) begin
    if (rstN && popReq && popValid && !collision) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12 unexpected word", int'(popData), -1);
      end else begin
        logic [DW:0] e;
        e = expQ.pop_front();
        check({popLast, popData} == e, "R12 word order", int'({popLast, popData}), int'(e));
        if (popLast) curFrame.delete();
        else curFrame.push_back(e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    tick();
    tick();
    check(txStart == 0 && svcReq == 0 && underrun == 0 && popValid == 0, "R11 outputs in reset",
          int'({txStart, svcReq, underrun, popValid}), 0);
    rstN = 1'b1;
    tick();
    check(pushReady == 1 && popValid == 0 && txStart == 0, "R11 after reset",
          int'({pushReady, popValid, txStart}), 4);

    // R3: threshold write gated by idle
    thrWrEn = 1'b1; thrWrData = 7'd6; txIdle = 1'b0;
    tick();
    thrWrEn = 1'b0;
    check(thrCur == 7'd2, "R3 write ignored when busy", int'(thrCur), 2);
    thrWrEn = 1'b1; thrWrData = 7'd4; txIdle = 1'b1;
    tick();
    thrWrEn = 1'b0; txIdle = 1'b0;
    check(thrCur == 7'd4, "R3 write taken when idle", int'(thrCur), 4);

    // R4: 2 + 4 + 4 = 10 > 8 with size 8, fine with size 16
    check(cfgErr == 1, "R4 error at depth 8", int'(cfgErr), 1);
    sizeSel = 2'd1;
    #1;
    check(cfgErr == 0, "R4 clean at depth 16", int'(cfgErr), 0);

    // R1 and R8: threshold start, watermark request
    pushWord(8'h10, 1'b0);
    check(svcReq == 1, "R8 below watermark", int'(svcReq), 1);
    pushWord(8'h11, 1'b0);
    pushWord(8'h12, 1'b0);
    check(txStart == 0, "R1 below threshold", int'(txStart), 0);
    pushWord(8'h13, 1'b0);
    check(txStart == 1, "R1 threshold reached", int'(txStart), 1);
    check(svcReq == 0, "R8 at or above watermark", int'(svcReq), 0);

    // R6: drain mid-frame then pull once more
    popWords(4);
    popReq = 1'b1;
    tick();
    popReq = 1'b0;
    check(underrun == 1, "R6 underrun pulse", int'(underrun), 1);
    tick();
    check(underrun == 0, "R6 underrun ends", int'(underrun), 0);
    pushWord(8'h14, 1'b1);
    popWords(1);

    // R2: whole short frame below threshold
    pushWord(8'h20, 1'b0);
    check(txStart == 0, "R2 no end word yet", int'(txStart), 0);
    pushWord(8'h21, 1'b1);
    check(txStart == 1, "R2 whole frame held", int'(txStart), 1);
    popWords(2);
    check(txStart == 0 && popValid == 0, "R2 drained", int'({txStart, popValid}), 0);

    // R9 and R10: full-duplex fill to depth 16
    for (int i = 0; i < 16; i++) pushWord(8'h40 + 8'(i), (i % 8) == 7);
    check(pushReady == 0, "R10 full refuses push", int'(pushReady), 0);
    pushWord(8'hEE, 1'b0);
    popWords(1);
    check(pushReady == 1, "R9 read frees entry", int'(pushReady), 1);
    popWords(15);
    check(popValid == 0, "R10 empty refuses pop", int'(popValid), 0);
    popReq = 1'b1;
    tick();
    popReq = 1'b0;
    check(underrun == 0, "R6 no underrun between frames", int'(underrun), 0);

    // R5 and R7: half-duplex retention and rewind
    halfDuplex = 1'b1;
    for (int i = 0; i < 16; i++) pushWord(8'h80 + 8'(i), i == 15);
    popWords(3);
    check(pushReady == 0, "R5 sent words still held", int'(pushReady), 0);
    popReq = 1'b1;
    collision = 1'b1;
    for (int i = curFrame.size() - 1; i >= 0; i--) expQ.push_front(curFrame[i]);
    curFrame.delete();
    tick();
    collision = 1'b0;
    popReq = 1'b0;
    check(txStart == 1, "R7 start re-armed after rewind", int'(txStart), 1);
    popWords(3);
    colWindowDone = 1'b1;
    tick();
    colWindowDone = 1'b0;
    check(pushReady == 1, "R5 window done frees space", int'(pushReady), 1);
    popWords(13);

    // R13: frame end frees held entries in half duplex
    for (int i = 0; i < 4; i++) pushWord(8'hC0 + 8'(i), i == 3);
    popWords(3);
    check(svcReq == 0, "R13 entries held mid-frame", int'(svcReq), 0);
    popWords(1);
    check(svcReq == 1, "R13 frame end frees all", int'(svcReq), 1);

    tick();
    check(expQ.size() == 0, "R12 all words delivered", expQ.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule